// File: doc/BRIEF.md
# Banked Working-Register File with Return Stack

This block is the internal scratch RAM of a small 8-bit controller. Sixty-four bytes of storage serve three purposes at the same time. Eight working registers are reachable directly by a 3-bit register number. A bank-select flag moves those eight registers between two windows of the RAM. Two of the working registers also act as pointers, so their contents can address any byte of the RAM indirectly.

A region of the same RAM holds the subroutine-return stack. It has eight two-byte slots, which a 3-bit stack pointer selects. A push saves a 12-bit return address together with 4 status bits and then advances the pointer. A pop steps the pointer back and returns the saved address and status. The pointer wraps silently in both directions. The stack bytes are ordinary RAM, so software can also read or patch them through the pointer registers.

Direct and indirect reads are combinational. Writes, pushes, pops and bank changes take effect at the rising clock edge. The stack pointer and the bank flag are visible as outputs so that surrounding status logic can use them.

Top module: `regbank_stack`

## Requirements
- R1: After reset, `stk_ptr` is 0, `bank_sel` is 0 and the pop outputs are 0. RAM contents are not initialised.
- R2: With bank 0 active, direct register `k` (0..7) is RAM location `k`. With bank 1 active it is location `24+k`. A direct write lands at the clock edge, and `dir_rdata` shows the current contents combinationally.
- R3: The indirect port uses the low 6 bits of working register 0 (`ind_sel`=0) or 1 (`ind_sel`=1) of the active bank as a RAM address and ignores the upper 2 bits. It can read and write all 64 locations.
- R4: A push writes into slot `p`, where `p` is the current pointer. Location `8+2p` receives address bits 7..0. Location `9+2p` receives address bits 11..8 in bits 3..0 and the status in bits 7..4. The pointer then becomes `p+1`.
- R5: A pop sets the pointer to `p-1`. From the next cycle on, `pop_addr` and `pop_stat` show the slot at the new pointer, decoded with the R4 byte layout.
- R6: The pointer wraps from 7 to 0 on a push and from 0 to 7 on a pop. A ninth nested push overwrites locations 8 and 9 without any error.
- R7: Stack locations behave as ordinary RAM. Bytes written through the indirect port are returned by a later pop of that slot, and pushed bytes are readable through the indirect port.
- R8: A push and a pop in the same cycle have no effect. The pointer, the RAM and the pop outputs all stay unchanged.
- R9: When several writes hit one location in the same cycle, a push write wins over an indirect write, and an indirect write wins over a direct write.
- R10: `bank_sel` loads `bank_val` in a cycle with `bank_we` high and holds its value otherwise.
- R11: `pop_addr` and `pop_stat` hold their value in every cycle that performs no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_we | input | 1 | Load the bank-select flag |
| bank_val | input | 1 | New bank-select value |
| bank_sel | output | 1 | Active register bank |
| dir_idx | input | 3 | Direct register number |
| dir_we | input | 1 | Direct write enable |
| dir_wdata | input | 8 | Direct write data |
| dir_rdata | output | 8 | Direct read data |
| ind_sel | input | 1 | Pointer choice: working register 0 or 1 |
| ind_we | input | 1 | Indirect write enable |
| ind_wdata | input | 8 | Indirect write data |
| ind_rdata | output | 8 | Indirect read data |
| push | input | 1 | Push strobe |
| push_addr | input | 12 | Return address to save |
| push_stat | input | 4 | Status bits to save |
| pop | input | 1 | Pop strobe |
| pop_addr | output | 12 | Return address from the last pop |
| pop_stat | output | 4 | Status bits from the last pop |
| stk_ptr | output | 3 | Current stack pointer |

## Verification
The bench sweeps every working register in both banks and every one of the 64 locations through the indirect port. Pointer values carry junk in their upper bits, so a design that decodes all 8 pointer bits would address outside the RAM or alias the wrong byte. It fills all eight stack slots, pushes a ninth time and pops back across the wrap. A pointer that saturated or flagged an error there would return the wrong slot, and a pop that read before decrementing would return the slot above. It also aims same-cycle collisions at one location (push against indirect, indirect against direct) and issues a simultaneous push and pop. A wrong priority order leaves the losing byte in RAM, and a half-handled collision moves the pointer.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

   // write port order: higher index wins on a collision
   localparam int WP_DIR    = 0;
   localparam int WP_IND    = 1;
   localparam int WP_STK_LO = 2;
   localparam int WP_STK_HI = 3;
   localparam int NUM_WP    = 4;

   // plain read ports
   localparam int RP_DIR    = 0;
   localparam int RP_POP_LO = 1;
   localparam int RP_POP_HI = 2;
   localparam int NUM_RP    = 3;

   typedef enum logic [1:0] {
      STK_IDLE = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2,
      STK_BOTH = 2'd3
   } stk_op_e;

endpackage

// File: rtl/rb_stack_ptr.sv
module rb_stack_ptr #(
   parameter int SP_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic            pop,
   output logic [SP_W-1:0] sp
);
   import regbank_pkg::*;

   stk_op_e op;
   assign op = stk_op_e'({pop, push});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp <= '0;
      end else begin
         case (op)
            STK_PUSH: sp <= sp + SP_W'(1);
            STK_POP:  sp <= sp - SP_W'(1);
            default:  sp <= sp;
         endcase
      end
   end

   // R4 R6
   sp_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> (sp == SP_W'($past(sp) + SP_W'(1))));

   // R5 R6
   sp_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> (sp == SP_W'($past(sp) - SP_W'(1))));

   // R8
   sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push == pop) |=> $stable(sp));

endmodule

// File: rtl/rb_addr_map.sv
module rb_addr_map #(
   parameter int ADDR_W     = 6,
   parameter int IDX_W      = 3,
   parameter int BANK1_BASE = 24
) (
   input  logic              bank,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam int NREG = 1 << IDX_W;

   generate
      if ((BANK1_BASE % NREG) == 0) begin : g_aligned
         // aligned window: the bank offset never overlaps the index bits
         assign addr = (bank ? ADDR_W'(BANK1_BASE) : '0) | ADDR_W'(idx);
      end else begin : g_offset
         assign addr = (bank ? ADDR_W'(BANK1_BASE) : '0) + ADDR_W'(idx);
      end
   endgenerate

endmodule

// File: rtl/rb_ram.sv
module rb_ram #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   parameter int ADDR_W = 6
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic [regbank_pkg::NUM_WP-1:0]            we,
   input  logic [regbank_pkg::NUM_WP-1:0][ADDR_W-1:0] waddr,
   input  logic [regbank_pkg::NUM_WP-1:0][DATA_W-1:0] wdata,
   input  logic [regbank_pkg::NUM_RP-1:0][ADDR_W-1:0] raddr,
   output logic [regbank_pkg::NUM_RP-1:0][DATA_W-1:0] rdata,
   input  logic [ADDR_W-1:0]                          ptr_addr,
   output logic [ADDR_W-1:0]                          ind_addr,
   output logic [DATA_W-1:0]                          ind_rdata
);
   import regbank_pkg::*;

   logic [DATA_W-1:0] mem [DEPTH];

   // later ports overwrite earlier ones in the same edge
   always_ff @(posedge clk) begin
      for (int w = 0; w < NUM_WP; w++) begin
         if (we[w]) mem[waddr[w]] <= wdata[w];
      end
   end

   generate
      for (genvar r = 0; r < NUM_RP; r++) begin : g_rd
         assign rdata[r] = mem[raddr[r]];
      end
   endgenerate

   // pointer fetch and the dependent data fetch
   assign ind_addr  = mem[ptr_addr][ADDR_W-1:0];
   assign ind_rdata = mem[ind_addr];

   // R9: a push byte always survives the edge
   stk_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we[WP_STK_LO] |=> (mem[$past(waddr[WP_STK_LO])] == $past(wdata[WP_STK_LO])));

endmodule

// File: rtl/regbank_stack.sv
module regbank_stack #(
   parameter int DATA_W     = 8,
   parameter int DEPTH      = 64,
   parameter int NREG       = 8,
   parameter int BANK1_BASE = 24,
   parameter int STK_BASE   = 8,
   parameter int STK_LEVELS = 8,
   parameter int PC_W       = 12,
   parameter int STAT_W     = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bank_we,
   input  logic                          bank_val,
   output logic                          bank_sel,
   input  logic [$clog2(NREG)-1:0]       dir_idx,
   input  logic                          dir_we,
   input  logic [DATA_W-1:0]             dir_wdata,
   output logic [DATA_W-1:0]             dir_rdata,
   input  logic                          ind_sel,
   input  logic                          ind_we,
   input  logic [DATA_W-1:0]             ind_wdata,
   output logic [DATA_W-1:0]             ind_rdata,
   input  logic                          push,
   input  logic [PC_W-1:0]               push_addr,
   input  logic [STAT_W-1:0]             push_stat,
   input  logic                          pop,
   output logic [PC_W-1:0]               pop_addr,
   output logic [STAT_W-1:0]             pop_stat,
   output logic [$clog2(STK_LEVELS)-1:0] stk_ptr
);
   import regbank_pkg::*;

   localparam int ADDR_W = $clog2(DEPTH);
   localparam int IDX_W  = $clog2(NREG);
   localparam int SP_W   = $clog2(STK_LEVELS);
   localparam int HI_W   = PC_W - DATA_W;

   // elaboration-time parameter checks
   generate
      if ((1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (DATA_W < ADDR_W) begin : g_bad_ptr
         $error("a pointer byte must cover the whole RAM");
      end
      if (2 * DATA_W != PC_W + STAT_W) begin : g_bad_pack
         $error("address plus status must fill exactly two bytes");
      end
      if (BANK1_BASE + NREG > DEPTH || STK_BASE + 2 * STK_LEVELS > DEPTH) begin : g_bad_map
         $error("bank or stack window exceeds the RAM");
      end
      if ((STK_BASE % 2) != 0 || (1 << SP_W) != STK_LEVELS) begin : g_bad_stk
         $error("stack base must be even and level count a power of two");
      end
   endgenerate

   // bank flag
   logic bank_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bank_q <= 1'b0;
      else if (bank_we) bank_q <= bank_val;
   end
   assign bank_sel = bank_q;

   // R10
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_we |=> $stable(bank_q));

   // stack pointer
   logic [SP_W-1:0] sp;
   rb_stack_ptr #(.SP_W(SP_W)) u_sp (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .sp    (sp)
   );
   assign stk_ptr = sp;

   logic do_push, do_pop;
   assign do_push = push & ~pop;
   assign do_pop  = pop & ~push;

   // address generation
   logic [ADDR_W-1:0] dir_a, ptr_a, ind_a;
   rb_addr_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BANK1_BASE(BANK1_BASE)) u_dir_map (
      .bank (bank_q),
      .idx  (dir_idx),
      .addr (dir_a)
   );
   rb_addr_map #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BANK1_BASE(BANK1_BASE)) u_ptr_map (
      .bank (bank_q),
      .idx  (IDX_W'(ind_sel)),
      .addr (ptr_a)
   );

   logic [SP_W-1:0]   sp_dec;
   logic [ADDR_W-1:0] push_lo_a, pop_lo_a;
   assign sp_dec    = sp - SP_W'(1);
   assign push_lo_a = ADDR_W'(STK_BASE) + ADDR_W'({sp, 1'b0});
   assign pop_lo_a  = ADDR_W'(STK_BASE) + ADDR_W'({sp_dec, 1'b0});

   // RAM ports
   logic [NUM_WP-1:0]             we;
   logic [NUM_WP-1:0][ADDR_W-1:0] waddr;
   logic [NUM_WP-1:0][DATA_W-1:0] wdata;
   logic [NUM_RP-1:0][ADDR_W-1:0] raddr;
   logic [NUM_RP-1:0][DATA_W-1:0] rdata;

   always_comb begin
      we[WP_DIR]       = dir_we;
      waddr[WP_DIR]    = dir_a;
      wdata[WP_DIR]    = dir_wdata;
      we[WP_IND]       = ind_we;
      waddr[WP_IND]    = ind_a;
      wdata[WP_IND]    = ind_wdata;
      we[WP_STK_LO]    = do_push;
      waddr[WP_STK_LO] = push_lo_a;
      wdata[WP_STK_LO] = push_addr[DATA_W-1:0];
      we[WP_STK_HI]    = do_push;
      waddr[WP_STK_HI] = push_lo_a + ADDR_W'(1);
      wdata[WP_STK_HI] = {push_stat, push_addr[PC_W-1:DATA_W]};
      raddr[RP_DIR]    = dir_a;
      raddr[RP_POP_LO] = pop_lo_a;
      raddr[RP_POP_HI] = pop_lo_a + ADDR_W'(1);
   end

   rb_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (we),
      .waddr     (waddr),
      .wdata     (wdata),
      .raddr     (raddr),
      .rdata     (rdata),
      .ptr_addr  (ptr_a),
      .ind_addr  (ind_a),
      .ind_rdata (ind_rdata)
   );
   assign dir_rdata = rdata[RP_DIR];

   // pop result register
   logic [PC_W-1:0]   pop_addr_q;
   logic [STAT_W-1:0] pop_stat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_addr_q <= '0;
         pop_stat_q <= '0;
      end else if (do_pop) begin
         pop_addr_q <= {rdata[RP_POP_HI][HI_W-1:0], rdata[RP_POP_LO]};
         pop_stat_q <= rdata[RP_POP_HI][DATA_W-1:HI_W];
      end
   end
   assign pop_addr = pop_addr_q;
   assign pop_stat = pop_stat_q;

   // R11 R8
   pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !do_pop |=> ($stable(pop_addr_q) && $stable(pop_stat_q)));

endmodule

// File: tb/regbank_stack_bench.sv
module regbank_stack_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bank_we = 1'b0, bank_val = 1'b0;
   logic        bank_sel;
   logic [2:0]  dir_idx = '0;
   logic        dir_we = 1'b0;
   logic [7:0]  dir_wdata = '0, dir_rdata;
   logic        ind_sel = 1'b0, ind_we = 1'b0;
   logic [7:0]  ind_wdata = '0, ind_rdata;
   logic        push = 1'b0, pop = 1'b0;
   logic [11:0] push_addr = '0, pop_addr;
   logic [3:0]  push_stat = '0, pop_stat;
   logic [2:0]  stk_ptr;

   regbank_stack u_regbank_stack (
      .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_val(bank_val), .bank_sel(bank_sel),
      .dir_idx(dir_idx), .dir_we(dir_we), .dir_wdata(dir_wdata), .dir_rdata(dir_rdata),
      .ind_sel(ind_sel), .ind_we(ind_we), .ind_wdata(ind_wdata), .ind_rdata(ind_rdata),
      .push(push), .push_addr(push_addr), .push_stat(push_stat), .pop(pop),
      .pop_addr(pop_addr), .pop_stat(pop_stat), .stk_ptr(stk_ptr)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   // bench model of the RAM and state
   logic [7:0] m [64];
   logic       bank_m = 1'b0;
   logic [2:0] sp_m = '0;

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int base();
      return bank_m ? 24 : 0;
   endfunction

   task automatic set_bank(logic b);
      bank_we = 1'b1; bank_val = b; step(); bank_we = 1'b0;
      bank_m = b;
   endtask

   task automatic dwrite(int idx, logic [7:0] v);
      dir_idx = 3'(idx); dir_wdata = v; dir_we = 1'b1; step(); dir_we = 1'b0;
      m[base() + idx] = v;
   endtask

   task automatic iwrite(logic sel, logic [7:0] v);
      int a;
      a = int'(m[base() + int'(sel)][5:0]);
      ind_sel = sel; ind_wdata = v; ind_we = 1'b1; step(); ind_we = 1'b0;
      m[a] = v;
   endtask

   task automatic dread(int idx, string tag);
      dir_idx = 3'(idx); #1;
      check(tag, 16'(dir_rdata), 16'(m[base() + idx]));
   endtask

   task automatic iread(logic sel, string tag);
      ind_sel = sel; #1;
      check(tag, 16'(ind_rdata), 16'(m[int'(m[base() + int'(sel)][5:0])]));
   endtask

   task automatic do_push(logic [11:0] a, logic [3:0] s);
      push = 1'b1; push_addr = a; push_stat = s; step(); push = 1'b0;
      m[8 + 2*int'(sp_m)] = a[7:0];
      m[9 + 2*int'(sp_m)] = {s, a[11:8]};
      sp_m = sp_m + 3'd1;
      check("R4 pointer after push", 16'(stk_ptr), 16'(sp_m));
   endtask

   task automatic do_pop(string tag);
      logic [7:0] lo, hi;
      pop = 1'b1; step(); pop = 1'b0;
      sp_m = sp_m - 3'd1;
      lo = m[8 + 2*int'(sp_m)];
      hi = m[9 + 2*int'(sp_m)];
      check({tag, " addr"}, 16'(pop_addr), 16'({hi[3:0], lo}));
      check({tag, " stat"}, 16'(pop_stat), 16'(hi[7:4]));
      check({tag, " pointer"}, 16'(stk_ptr), 16'(sp_m));
   endtask

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin : main
      logic [11:0] a_hold;
      logic [3:0]  s_hold;
      repeat (3) step();
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 pointer", 16'(stk_ptr), 16'h0);
      check("R1 bank", 16'(bank_sel), 16'h0);
      check("R1 pop addr", 16'(pop_addr), 16'h0);
      check("R1 pop stat", 16'(pop_stat), 16'h0);

      // R2: direct registers in both banks, then cross-check location via pointer
      for (int b = 0; b < 2; b++) begin
         set_bank(1'(b));
         check("R10 bank load", 16'(bank_sel), 16'(b));
         for (int k = 0; k < 8; k++) dwrite(k, 8'(16*b + 3*k + 1));
         for (int k = 0; k < 8; k++) dread(k, "R2 direct readback");
      end
      set_bank(1'b0);
      for (int k = 0; k < 8; k++) begin
         dwrite(1, 8'(24 + k));
         iread(1'b1, "R2 bank1 window via pointer");
      end

      // R3: write every location indirectly, pointers carry junk upper bits
      for (int loc = 0; loc < 64; loc++) begin
         if (loc == 0) begin
            dwrite(1, 8'(loc) | 8'hC0);
            iwrite(1'b1, 8'((loc * 37 + 5) & 255));
         end else begin
            dwrite(0, 8'(loc) | 8'h80);
            iwrite(1'b0, 8'((loc * 37 + 5) & 255));
         end
      end
      for (int loc = 0; loc < 64; loc++) begin
         dwrite(0, 8'(loc) | 8'h40);
         iread(1'b0, "R3 indirect sweep");
      end

      // R4 R6: eight pushes fill the stack, a ninth wraps onto slot 0
      for (int n = 0; n < 9; n++) begin
         do_push(12'(n * 12'h1A3 + 12'h05C), 4'(n + 3));
      end
      check("R6 wrapped pointer", 16'(stk_ptr), 16'd1);
      dwrite(0, 8'd8);
      iread(1'b0, "R6 ninth push overwrote location 8");
      check("R6 location 8 value", 16'(ind_rdata), 16'(8'((8 * 12'h1A3 + 12'h05C) & 255)));
      dwrite(0, 8'd9);
      iread(1'b0, "R7 pushed byte visible at location 9");
      dwrite(0, 8'd23);
      iread(1'b0, "R7 pushed byte visible at location 23");

      // R5 R6: pop to 0, then wrap down to 7
      do_pop("R5 pop");
      do_pop("R6 pop wrap");
      check("R6 pointer after wrap", 16'(stk_ptr), 16'd7);

      // R7: patch slot 6 through the indirect port, then pop it
      dwrite(0, 8'(8 + 2*6));
      iwrite(1'b0, 8'hA5);
      dwrite(0, 8'(9 + 2*6));
      iwrite(1'b0, 8'h9C);
      do_pop("R7 patched slot");
      check("R7 patched addr", 16'(pop_addr), 16'h0CA5);
      check("R7 patched stat", 16'(pop_stat), 16'h9);

      // R8: push and pop together change nothing
      a_hold = pop_addr; s_hold = pop_stat;
      dwrite(1, 8'(8 + 2*int'(sp_m)));
      push = 1'b1; pop = 1'b1; push_addr = 12'hFFF; push_stat = 4'hF;
      step();
      push = 1'b0; pop = 1'b0;
      check("R8 pointer held", 16'(stk_ptr), 16'(sp_m));
      check("R8 pop addr held", 16'(pop_addr), 16'(a_hold));
      iread(1'b1, "R8 stack byte untouched");

      // R9: indirect beats direct on the same register
      dwrite(0, 8'd2);
      dir_idx = 3'd2; dir_wdata = 8'h11; dir_we = 1'b1;
      ind_sel = 1'b0; ind_wdata = 8'h22; ind_we = 1'b1;
      step();
      dir_we = 1'b0; ind_we = 1'b0;
      m[2] = 8'h22;
      dread(2, "R9 indirect over direct");

      // R9: push beats indirect on a stack byte
      dwrite(1, 8'(8 + 2*int'(sp_m)));
      ind_sel = 1'b1; ind_wdata = 8'h33; ind_we = 1'b1;
      push = 1'b1; push_addr = 12'h7E4; push_stat = 4'h6;
      step();
      ind_we = 1'b0; push = 1'b0;
      m[8 + 2*int'(sp_m)] = 8'hE4;
      m[9 + 2*int'(sp_m)] = 8'h67;
      sp_m = sp_m + 3'd1;
      iread(1'b1, "R9 push over indirect");
      check("R9 push byte value", 16'(ind_rdata), 16'h00E4);

      // R10: bank value ignored without load strobe
      bank_val = 1'b1; step();
      check("R10 bank held", 16'(bank_sel), 16'h0);
      bank_val = 1'b0;

      // R11: pop outputs hold across non-pop cycles
      a_hold = pop_addr; s_hold = pop_stat;
      do_push(12'h321, 4'hA);
      repeat (3) step();
      check("R11 pop addr held", 16'(pop_addr), 16'(a_hold));
      check("R11 pop stat held", 16'(pop_stat), 16'(s_hold));
      do_pop("R5 pop after hold");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule